// File: doc/BRIEF.md
# Second-Operand Shifter

This block forms the second source operand of a data-processing operation, together with the shifter carry-out that a flag update would use. An immediate operand is carried as a short constant plus a small rotate field. The constant is zero-extended to the datapath width and rotated right by twice the rotate field. A register operand is shifted left, shifted right logically or arithmetically, or rotated right. The shift amount comes from a five-bit constant or from the low byte of a second register.

The logic that computes the operand is combinational. A parameter selects whether the operand and carry leave through a pipeline register or straight from that logic. By default the register is present, so each result appears one clock after its inputs, and an asynchronous active-low reset clears it. The ALU, the command decode and the flag register are outside this block.

Top module: `operand_shifter`

## Requirements
- R1: While `rst_n` is low, `operand_out` and `carry_out` are zero. With the default output register, a result appears at the first rising clock edge after its inputs and holds until the next edge.
- R2: With `imm_sel`=1, `operand_out` equals `imm_val`, zero-extended to 32 bits and rotated right by 2×`imm_rot`. For example, 0xFF with rotate field 14 gives 0x00000FF0.
- R3: With `imm_sel`=1 and `imm_rot`=0, `operand_out` is `imm_val` zero-extended and `carry_out` equals `carry_in`.
- R4: With `imm_sel`=1 and `imm_rot`≠0, `carry_out` equals bit 31 of `operand_out`.
- R5: With `imm_sel`=0, `rm_val` is shifted by the selected amount. The `shift_kind` encoding is 00 logical left, 01 logical right, 10 arithmetic right and 11 rotate right. For amounts 1 to 31, `carry_out` is the last bit shifted out; for rotate right it is the result's bit 31.
- R6: With `imm_sel`=0, `amt_from_reg`=0 and `amt_const`=0, `operand_out` equals `rm_val` and `carry_out` equals `carry_in`, whatever `shift_kind` is.
- R7: With `amt_from_reg`=1, only bits 7:0 of `rs_val` form the amount; bits 31:8 have no effect.
- R8: With `amt_from_reg`=1 and `rs_val[7:0]`=0, `operand_out` equals `rm_val` and `carry_out` equals `carry_in`.
- R9: For a register amount of 32 or more, logical left and logical right give 0. At exactly 32 the carry is `rm_val[0]` for a left shift and `rm_val[31]` for a right shift; above 32 the carry is 0.
- R10: For a register amount of 32 or more, arithmetic right gives 32 copies of `rm_val[31]`, and `carry_out` is `rm_val[31]`.
- R11: Rotate right with a register amount uses that amount modulo 32. A nonzero multiple of 32 returns `rm_val` unchanged, with `carry_out`=`rm_val[31]`.
- R12: `amt_from_reg` chooses between `rs_val[7:0]` and `amt_const`; the source that is not chosen has no effect. With `imm_sel`=1, `rm_val`, `rs_val` and the shift controls have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| imm_sel | input | 1 | 1 selects the rotated immediate, 0 the shifted register |
| imm_val | input | 8 | Immediate constant |
| imm_rot | input | 4 | Immediate rotate field, in steps of two bit positions |
| rm_val | input | 32 | Register value to be shifted |
| amt_from_reg | input | 1 | 1 takes the shift amount from `rs_val[7:0]` |
| amt_const | input | 5 | Constant shift amount |
| rs_val | input | 32 | Register that supplies the shift amount |
| shift_kind | input | 2 | Shift type: 00 LSL, 01 LSR, 10 ASR, 11 ROR |
| carry_in | input | 1 | Incoming carry flag |
| operand_out | output | 32 | Second operand |
| carry_out | output | 1 | Shifter carry-out |

## Verification
Every operand and carry result is due one rising edge after its inputs are applied, because the default build registers both outputs. The bench drives inputs on the falling edge and compares on the next falling edge, half a period after the capturing edge. One directed test also samples just before the capturing edge and confirms that the previous result is still held. The checker's properties use the same one-cycle relation, comparing present outputs with the past inputs.

// File: rtl/operand_shifter.sv
module operand_shifter #(
  parameter int DW      = 32,
  parameter int IMMW    = 8,
  parameter int ROTW    = 4,
  parameter int AMTW    = 8,
  parameter bit REG_OUT = 1'b1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   imm_sel,
  input  logic [IMMW-1:0]        imm_val,
  input  logic [ROTW-1:0]        imm_rot,
  input  logic [DW-1:0]          rm_val,
  input  logic                   amt_from_reg,
  input  logic [$clog2(DW)-1:0]  amt_const,
  input  logic [DW-1:0]          rs_val,
  input  logic [1:0]             shift_kind,
  input  logic                   carry_in,
  output logic [DW-1:0]          operand_out,
  output logic                   carry_out
);

  localparam int SHW = $clog2(DW);

  typedef enum logic [1:0] {
    SH_LSL = 2'b00,
    SH_LSR = 2'b01,
    SH_ASR = 2'b10,
    SH_ROR = 2'b11
  } kind_e;

  function automatic logic [DW-1:0] ror_f(input logic [DW-1:0] v, input logic [SHW-1:0] r);
    logic [2*DW-1:0] dbl;
    dbl = {v, v} >> r;
    return dbl[DW-1:0];
  endfunction

  // immediate path
  logic [DW-1:0]  imm_ext;
  logic [SHW-1:0] imm_amt;
  logic [DW-1:0]  imm_res;
  logic           imm_c;

  assign imm_ext = DW'(imm_val);
  assign imm_amt = SHW'({imm_rot, 1'b0});
  assign imm_res = ror_f(imm_ext, imm_amt);
  assign imm_c   = (imm_rot == '0) ? carry_in : imm_res[DW-1];

  // register path
  logic [AMTW-1:0] amt;
  logic [SHW-1:0]  lo;
  logic            over;
  logic            exact;
  logic [DW-1:0]   reg_res;
  logic            reg_c;

  assign amt   = amt_from_reg ? rs_val[AMTW-1:0] : AMTW'(amt_const);
  assign lo    = amt[SHW-1:0];
  assign over  = amt >= AMTW'(DW);
  assign exact = amt == AMTW'(DW);

  always_comb begin
    reg_res = rm_val;
    reg_c   = carry_in;
    if (amt != '0) begin
      unique case (kind_e'(shift_kind))
        SH_LSL: begin
          if (over) begin
            reg_res = '0;
            reg_c   = exact & rm_val[0];
          end else begin
            reg_res = rm_val << lo;
            reg_c   = rm_val[SHW'(DW - int'(lo))];
          end
        end
        SH_LSR: begin
          if (over) begin
            reg_res = '0;
            reg_c   = exact & rm_val[DW-1];
          end else begin
            reg_res = rm_val >> lo;
            reg_c   = rm_val[lo - SHW'(1)];
          end
        end
        SH_ASR: begin
          if (over) begin
            reg_res = {DW{rm_val[DW-1]}};
            reg_c   = rm_val[DW-1];
          end else begin
            reg_res = $signed(rm_val) >>> lo;
            reg_c   = rm_val[lo - SHW'(1)];
          end
        end
        SH_ROR: begin
          reg_res = ror_f(rm_val, lo);
          reg_c   = reg_res[DW-1];
        end
        default: begin
          reg_res = rm_val;
          reg_c   = carry_in;
        end
      endcase
    end
  end

  logic [DW-1:0] nxt_op;
  logic          nxt_c;

  assign nxt_op = imm_sel ? imm_res : reg_res;
  assign nxt_c  = imm_sel ? imm_c   : reg_c;

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          operand_out <= '0;
          carry_out   <= 1'b0;
        end else begin
          operand_out <= nxt_op;
          carry_out   <= nxt_c;
        end
      end
    end else begin : g_comb
      assign operand_out = nxt_op;
      assign carry_out   = nxt_c;
    end
  endgenerate

endmodule

// File: rtl/operand_shifter_chk.sv
module operand_shifter_chk #(
  parameter int DW      = 32,
  parameter int IMMW    = 8,
  parameter int ROTW    = 4,
  parameter int AMTW    = 8,
  parameter bit REG_OUT = 1'b1
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  imm_sel,
  input logic [IMMW-1:0]       imm_val,
  input logic [ROTW-1:0]       imm_rot,
  input logic [DW-1:0]         rm_val,
  input logic                  amt_from_reg,
  input logic [$clog2(DW)-1:0] amt_const,
  input logic [DW-1:0]         rs_val,
  input logic [1:0]            shift_kind,
  input logic                  carry_in,
  input logic [DW-1:0]         operand_out,
  input logic                  carry_out
);

  logic big_amt;
  assign big_amt = rs_val[AMTW-1:0] >= AMTW'(DW);

  generate
    if (REG_OUT) begin : g_props
      p_imm_plain_r3: assert property (@(posedge clk) disable iff (!rst_n)
        imm_sel && imm_rot == '0 |=>
          operand_out == DW'($past(imm_val)) && carry_out == $past(carry_in));

      p_imm_carry_r4: assert property (@(posedge clk) disable iff (!rst_n)
        imm_sel && imm_rot != '0 |=> carry_out == operand_out[DW-1]);

      p_imm_ones_r2: assert property (@(posedge clk) disable iff (!rst_n)
        imm_sel |=> $countones(operand_out) == $countones($past(imm_val)));

      p_const_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !imm_sel && !amt_from_reg && amt_const == '0 |=>
          operand_out == $past(rm_val) && carry_out == $past(carry_in));

      p_reg_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !imm_sel && amt_from_reg && rs_val[AMTW-1:0] == '0 |=>
          operand_out == $past(rm_val) && carry_out == $past(carry_in));

      p_big_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !imm_sel && amt_from_reg && big_amt && !shift_kind[1] |=> operand_out == '0);

      p_asr_fill_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !imm_sel && amt_from_reg && big_amt && shift_kind == 2'b10 |=>
          operand_out == {DW{$past(rm_val[DW-1])}} && carry_out == $past(rm_val[DW-1]));

      p_ror_ones_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !imm_sel && shift_kind == 2'b11 |=>
          $countones(operand_out) == $countones($past(rm_val)));
    end
  endgenerate

endmodule

bind operand_shifter operand_shifter_chk #(
  .DW(DW), .IMMW(IMMW), .ROTW(ROTW), .AMTW(AMTW), .REG_OUT(REG_OUT)
) u_chk (.*);

// File: tb/test_operand_shifter.sv
`timescale 1ns/1ps
module test_operand_shifter;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        imm_sel = 1'b0;
  logic [7:0]  imm_val = '0;
  logic [3:0]  imm_rot = '0;
  logic [31:0] rm_val = '0;
  logic        amt_from_reg = 1'b0;
  logic [4:0]  amt_const = '0;
  logic [31:0] rs_val = '0;
  logic [1:0]  shift_kind = '0;
  logic        carry_in = 1'b0;
  logic [31:0] operand_out;
  logic        carry_out;

  int errors = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  operand_shifter i_operand_shifter (
    .clk(clk), .rst_n(rst_n), .imm_sel(imm_sel), .imm_val(imm_val), .imm_rot(imm_rot),
    .rm_val(rm_val), .amt_from_reg(amt_from_reg), .amt_const(amt_const), .rs_val(rs_val),
    .shift_kind(shift_kind), .carry_in(carry_in), .operand_out(operand_out), .carry_out(carry_out)
  );

  typedef struct packed {
    logic        isel;
    logic [7:0]  imm;
    logic [3:0]  rot;
    logic [31:0] rm;
    logic        freg;
    logic [4:0]  ac;
    logic [31:0] rs;
    logic [1:0]  kind;
    logic        cin;
    logic [31:0] eop;
    logic        ec;
    logic [7:0]  rq;
  } vec_t;

  localparam int NV = 24;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 8'hFF, 4'd14, 32'h0, 1'b0, 5'd0, 32'h0, 2'b00, 1'b1, 32'h00000FF0, 1'b0, 8'd2},  // R2
    '{1'b1, 8'h3F, 4'd4,  32'h0, 1'b0, 5'd0, 32'h0, 2'b00, 1'b1, 32'h3F000000, 1'b0, 8'd2},  // R2
    '{1'b1, 8'h81, 4'd1,  32'h0, 1'b0, 5'd0, 32'h0, 2'b00, 1'b1, 32'h40000020, 1'b0, 8'd4},  // R4
    '{1'b1, 8'h02, 4'd1,  32'h0, 1'b0, 5'd0, 32'h0, 2'b00, 1'b0, 32'h80000000, 1'b1, 8'd4},  // R4
    '{1'b1, 8'hA5, 4'd0,  32'h0, 1'b0, 5'd0, 32'h0, 2'b00, 1'b1, 32'h000000A5, 1'b1, 8'd3},  // R3
    '{1'b0, 8'h00, 4'd0,  32'hF000000F, 1'b0, 5'd4,  32'h0, 2'b00, 1'b0, 32'h000000F0, 1'b1, 8'd5},  // R5
    '{1'b0, 8'h00, 4'd0,  32'h00000003, 1'b0, 5'd1,  32'h0, 2'b01, 1'b0, 32'h00000001, 1'b1, 8'd5},  // R5
    '{1'b0, 8'h00, 4'd0,  32'h80000000, 1'b0, 5'd31, 32'h0, 2'b01, 1'b1, 32'h00000001, 1'b0, 8'd5},  // R5
    '{1'b0, 8'h00, 4'd0,  32'h80001234, 1'b0, 5'd8,  32'h0, 2'b10, 1'b1, 32'hFF800012, 1'b0, 8'd5},  // R5
    '{1'b0, 8'h00, 4'd0,  32'h12345678, 1'b0, 5'd4,  32'h0, 2'b11, 1'b0, 32'h81234567, 1'b1, 8'd5},  // R5
    '{1'b0, 8'h00, 4'd0,  32'hDEADBEEF, 1'b0, 5'd0,  32'h0, 2'b00, 1'b1, 32'hDEADBEEF, 1'b1, 8'd6},  // R6
    '{1'b0, 8'h00, 4'd0,  32'hDEADBEEF, 1'b0, 5'd0,  32'h0, 2'b01, 1'b0, 32'hDEADBEEF, 1'b0, 8'd6},  // R6
    '{1'b0, 8'h00, 4'd0,  32'hDEADBEEF, 1'b0, 5'd0,  32'h0, 2'b11, 1'b1, 32'hDEADBEEF, 1'b1, 8'd6},  // R6
    '{1'b0, 8'h00, 4'd0,  32'h12345678, 1'b1, 5'd7,  32'hFFFFFF00, 2'b00, 1'b1, 32'h12345678, 1'b1, 8'd8},  // R8
    '{1'b0, 8'h00, 4'd0,  32'h0000000F, 1'b1, 5'd31, 32'hABCDEF04, 2'b00, 1'b1, 32'h000000F0, 1'b0, 8'd7},  // R7
    '{1'b0, 8'h00, 4'd0,  32'h00000001, 1'b1, 5'd0,  32'h00000020, 2'b00, 1'b0, 32'h00000000, 1'b1, 8'd9},  // R9
    '{1'b0, 8'h00, 4'd0,  32'h80000000, 1'b1, 5'd0,  32'h00000020, 2'b01, 1'b0, 32'h00000000, 1'b1, 8'd9},  // R9
    '{1'b0, 8'h00, 4'd0,  32'hFFFFFFFF, 1'b1, 5'd0,  32'h00000028, 2'b00, 1'b1, 32'h00000000, 1'b0, 8'd9},  // R9
    '{1'b0, 8'h00, 4'd0,  32'h80000000, 1'b1, 5'd0,  32'h000000C8, 2'b10, 1'b0, 32'hFFFFFFFF, 1'b1, 8'd10}, // R10
    '{1'b0, 8'h00, 4'd0,  32'h7FFFFFFF, 1'b1, 5'd0,  32'h00000021, 2'b10, 1'b1, 32'h00000000, 1'b0, 8'd10}, // R10
    '{1'b0, 8'h00, 4'd0,  32'h12345678, 1'b1, 5'd0,  32'h00000024, 2'b11, 1'b0, 32'h81234567, 1'b1, 8'd11}, // R11
    '{1'b0, 8'h00, 4'd0,  32'h0000000F, 1'b1, 5'd0,  32'h00000040, 2'b11, 1'b1, 32'h0000000F, 1'b0, 8'd11}, // R11
    '{1'b1, 8'h01, 4'd0,  32'hFFFFFFFF, 1'b1, 5'd9,  32'h00000003, 2'b10, 1'b0, 32'h00000001, 1'b0, 8'd12}, // R12
    '{1'b0, 8'h00, 4'd0,  32'h00000100, 1'b0, 5'd4,  32'h00000001, 2'b01, 1'b1, 32'h00000010, 1'b0, 8'd12}  // R12
  };

  task automatic drive(input vec_t v);
    imm_sel = v.isel; imm_val = v.imm; imm_rot = v.rot; rm_val = v.rm;
    amt_from_reg = v.freg; amt_const = v.ac; rs_val = v.rs;
    shift_kind = v.kind; carry_in = v.cin;
  endtask

  task automatic check(input int rq, input logic [31:0] eop, input logic ec);
    checks++;
    if (operand_out !== eop || carry_out !== ec) begin
      errors++;
      $display("FAIL R%0d: operand=%h carry=%b expected operand=%h carry=%b",
               rq, operand_out, carry_out, eop, ec);
    end
  endtask

  initial begin
    #1000000;
    errors++; checks++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R1: reset clears outputs even with active inputs
    drive(VEC[0]);
    repeat (3) @(negedge clk);
    check(1, 32'h0, 1'b0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VEC[i]);
      @(negedge clk);
      check(int'(VEC[i].rq), VEC[i].eop, VEC[i].ec);
    end

    // R1: one-cycle latency, previous result held until the capturing edge
    @(negedge clk);
    drive(VEC[0]);
    @(negedge clk);
    check(1, 32'h00000FF0, 1'b0);
    drive(VEC[9]);
    #1;
    check(1, 32'h00000FF0, 1'b0);
    @(negedge clk);
    check(1, 32'h81234567, 1'b1);

    // R7: upper bits of rs_val ignored (amount 1 with noisy upper bits)
    @(negedge clk);
    imm_sel = 1'b0; amt_from_reg = 1'b1; rs_val = 32'h5A5A5A01;
    rm_val = 32'h00000002; shift_kind = 2'b01; carry_in = 1'b1;
    @(negedge clk);
    check(7, 32'h00000001, 1'b0);

    // R1: asynchronous reset clears a held result
    rst_n = 1'b0;
    #1;
    check(1, 32'h0, 1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule